// File: doc/BRIEF.md
# SYSREF Capture and Timing Realignment

This block lives in the converter's device-clock domain, where one clock cycle equals one sample. It samples the SYSREF input on each rising clock edge and delays the sampled value by a selectable whole number of cycles. The delay absorbs board skew between SYSREF and the clock. The block then turns the first 0→1 transition of the delayed signal into a single realignment event. That event returns several internal timing generators to phase zero together: the four-phase core clock divider, the frame counter, the multi-frame (LMFC) counter and, in decimation mode, the decimator clock divider. In decimation mode it also issues an NCO phase reset.

Subclass 0 bring-up works without a SYSREF wire. A source select swaps the input for a manual bit driven by software, and writing that bit high and then low produces one event. Each destination has its own blocking control. Software can therefore, for example, realign only the frame and LMFC counters after the core clock divider is running. A separate gate keeps the NCO phase from being reset once the link is up.

The LMFC boundary and frame boundary strobes are registered outputs that feed the link layer. A one-cycle misalignment flag marks any event that moved the LMFC phase. With correctly timed periodic SYSREF, the flag stays quiet after the first alignment. A correctly timed period is a multiple of both 64 clocks and S×K clocks.

Top module: `sref_align_top`

## Requirements
- R1: With `src_sel`=0 and `dly_sel`=d, SYSREF first sampled high at rising edge E0 realigns the timing so that after edge E(2+d) `div_phase`=0 and `frame_strobe`=`lmfc_strobe`=1. The preceding cycle shows the unrealigned phase.
- R2: Only a 0→1 transition of the selected source makes an event. A source held high for many cycles realigns once, and the counters then advance freely.
- R3: `div_phase` advances 0,1,2,3,0 each cycle. An event resets it to 0 unless `mask_div`=1, in which case it keeps counting.
- R4: `frame_strobe` is high on every S-th cycle and `lmfc_strobe` on every S×K-th cycle, both counted from the last alignment. An event realigns both unless `mask_jesd`=1.
- R5: `dec_strobe` is high on every D-th cycle. An event realigns it only when `ddc_mode`=1 and `mask_dec`=0.
- R6: `nco_rst` is a one-cycle pulse in the realignment cycle when `ddc_mode`=1 and `nco_gate`=0. It stays low whenever `nco_gate`=1 or `ddc_mode`=0.
- R7: With `src_sel`=1, `sysref_in` is ignored. A rising `manual_bit` gives one event with the d=0 latency of R1, whatever `dly_sel` is. Holding the bit high gives no further event.
- R8: `misalign` pulses for one cycle, in the realignment cycle, when an event applied to the LMFC counter finds that counter away from its natural wrap to zero. It is low otherwise.
- R9: After alignment, SYSREF edges spaced by a multiple of LCM(64, S×K) cycles with a fixed delay cause no `misalign` and no phase change.
- R10: While `rst` is high, all counters read zero and all strobes, `nco_rst` and `misalign` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sysref_in | input | 1 | External SYSREF, sampled on rising edge |
| dly_sel | input | DLY_W | Capture delay in whole clock cycles |
| src_sel | input | 1 | 0 = external SYSREF, 1 = manual bit |
| manual_bit | input | 1 | Software SYSREF; a rising transition makes an event |
| mask_div | input | 1 | Block realignment of the core clock divider |
| mask_jesd | input | 1 | Block realignment of frame and LMFC counters |
| mask_dec | input | 1 | Block realignment of the decimator clock divider |
| ddc_mode | input | 1 | Decimation mode enable |
| nco_gate | input | 1 | Suppress NCO phase resets |
| div_phase | output | 2 | Core clock divider phase |
| frame_strobe | output | 1 | Frame boundary pulse |
| lmfc_strobe | output | 1 | Multi-frame boundary pulse |
| dec_strobe | output | 1 | Decimator clock enable pulse |
| nco_rst | output | 1 | NCO phase reset pulse |
| misalign | output | 1 | Event changed the LMFC phase |

## Verification
The realignment function is driven by several kinds of SYSREF and manual edges. A misplaced edge shows that the event lands exactly 3+d cycles after the drive and raises `misalign`. An edge timed to the natural LMFC wrap under a two-cycle delay separates a correct delay tap from an off-by-one, because any slip raises the flag. A long-high SYSREF and a long-high manual bit separate edge detection from level-triggered resets through the `div_phase` value seen later. Edges landing at phase 66 while one destination is blocked reveal which counters moved and which kept their natural phase 2. Toggling `sysref_in` while the manual source is selected shows whether the external path leaks through.

// File: rtl/sref_pkg.sv
package sref_pkg;

  typedef struct packed {
    logic div;
    logic jesd;
    logic dec;
  } sref_mask_t;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sref_capture.sv
module sref_capture #(
  parameter int MAX_DLY = 8,
  localparam int DLY_W = sref_pkg::cnt_width(MAX_DLY)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sysref_in,
  input  logic [DLY_W-1:0] dly_sel,
  output logic             sref_dly
);

  logic [MAX_DLY-1:0] taps;

  always_ff @(posedge clk) begin
    if (rst) taps[0] <= 1'b0;
    else     taps[0] <= sysref_in;
  end

  for (genvar i = 1; i < MAX_DLY; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) taps[i] <= 1'b0;
      else     taps[i] <= taps[i-1];
    end
  end

  assign sref_dly = taps[dly_sel];

endmodule

// File: rtl/sref_event.sv
module sref_event (
  input  logic clk,
  input  logic rst,
  input  logic ext_sref,
  input  logic manual_bit,
  input  logic src_sel,
  output logic ev
);

  logic man_q;
  logic prev_q;
  logic src;

  assign src = src_sel ? man_q : ext_sref;

  always_ff @(posedge clk) begin
    if (rst) begin
      man_q  <= 1'b0;
      prev_q <= 1'b0;
      ev     <= 1'b0;
    end else begin
      man_q  <= manual_bit;
      prev_q <= src;
      ev     <= src & ~prev_q;
    end
  end

endmodule

// File: rtl/sref_timing.sv
module sref_timing
  import sref_pkg::*;
#(
  parameter int SAMP_PER_FRAME = 4,
  parameter int FRAMES_PER_MF  = 16,
  parameter int DEC_FACTOR     = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev,
  input  sref_mask_t mask,
  input  logic       ddc_mode,
  input  logic       nco_gate,
  output logic [1:0] div_phase,
  output logic       frame_strobe,
  output logic       lmfc_strobe,
  output logic       dec_strobe,
  output logic       nco_rst,
  output logic       misalign
);

  localparam int FW = cnt_width(SAMP_PER_FRAME);
  localparam int KW = cnt_width(FRAMES_PER_MF);
  localparam int DW = cnt_width(DEC_FACTOR);
  localparam logic [FW-1:0] FRM_LAST = FW'(SAMP_PER_FRAME - 1);
  localparam logic [KW-1:0] MF_LAST  = KW'(FRAMES_PER_MF - 1);
  localparam logic [DW-1:0] DEC_LAST = DW'(DEC_FACTOR - 1);

  logic [FW-1:0] frm_q, frm_nat, frm_nxt;
  logic [KW-1:0] mf_q, mf_nat, mf_nxt;
  logic [DW-1:0] dec_q, dec_nxt;
  logic [1:0]    div_nxt;
  logic          hit_div, hit_jesd, hit_dec;

  assign hit_div  = ev & ~mask.div;
  assign hit_jesd = ev & ~mask.jesd;
  assign hit_dec  = ev & ~mask.dec & ddc_mode;

  always_comb begin
    frm_nat = (frm_q == FRM_LAST) ? '0 : frm_q + FW'(1);
    mf_nat  = mf_q;
    if (frm_q == FRM_LAST)
      mf_nat = (mf_q == MF_LAST) ? '0 : mf_q + KW'(1);
    frm_nxt = hit_jesd ? '0 : frm_nat;
    mf_nxt  = hit_jesd ? '0 : mf_nat;
    div_nxt = hit_div ? 2'd0 : div_phase + 2'd1;
    if (hit_dec)               dec_nxt = '0;
    else if (dec_q == DEC_LAST) dec_nxt = '0;
    else                        dec_nxt = dec_q + DW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_q        <= '0;
      mf_q         <= '0;
      dec_q        <= '0;
      div_phase    <= 2'd0;
      frame_strobe <= 1'b0;
      lmfc_strobe  <= 1'b0;
      dec_strobe   <= 1'b0;
      nco_rst      <= 1'b0;
      misalign     <= 1'b0;
    end else begin
      frm_q        <= frm_nxt;
      mf_q         <= mf_nxt;
      dec_q        <= dec_nxt;
      div_phase    <= div_nxt;
      frame_strobe <= (frm_nxt == '0);
      lmfc_strobe  <= (frm_nxt == '0) && (mf_nxt == '0);
      dec_strobe   <= (dec_nxt == '0);
      nco_rst      <= ev & ddc_mode & ~nco_gate;
      misalign     <= hit_jesd & ((frm_nat != '0) || (mf_nat != '0));
    end
  end

endmodule

// File: rtl/sref_align_top.sv
module sref_align_top
  import sref_pkg::*;
#(
  parameter int MAX_DLY        = 8,
  parameter int SAMP_PER_FRAME = 4,
  parameter int FRAMES_PER_MF  = 16,
  parameter int DEC_FACTOR     = 8,
  localparam int DLY_W = cnt_width(MAX_DLY)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sysref_in,
  input  logic [DLY_W-1:0] dly_sel,
  input  logic             src_sel,
  input  logic             manual_bit,
  input  logic             mask_div,
  input  logic             mask_jesd,
  input  logic             mask_dec,
  input  logic             ddc_mode,
  input  logic             nco_gate,
  output logic [1:0]       div_phase,
  output logic             frame_strobe,
  output logic             lmfc_strobe,
  output logic             dec_strobe,
  output logic             nco_rst,
  output logic             misalign
);

  logic       sref_dly;
  logic       sref_ev;
  sref_mask_t mask;

  assign mask = '{div: mask_div, jesd: mask_jesd, dec: mask_dec};

  sref_capture #(.MAX_DLY(MAX_DLY)) u_cap (
    .clk(clk), .rst(rst), .sysref_in(sysref_in),
    .dly_sel(dly_sel), .sref_dly(sref_dly)
  );

  sref_event u_evt (
    .clk(clk), .rst(rst), .ext_sref(sref_dly),
    .manual_bit(manual_bit), .src_sel(src_sel), .ev(sref_ev)
  );

  sref_timing #(
    .SAMP_PER_FRAME(SAMP_PER_FRAME),
    .FRAMES_PER_MF(FRAMES_PER_MF),
    .DEC_FACTOR(DEC_FACTOR)
  ) u_tim (
    .clk(clk), .rst(rst), .ev(sref_ev), .mask(mask),
    .ddc_mode(ddc_mode), .nco_gate(nco_gate),
    .div_phase(div_phase), .frame_strobe(frame_strobe),
    .lmfc_strobe(lmfc_strobe), .dec_strobe(dec_strobe),
    .nco_rst(nco_rst), .misalign(misalign)
  );

endmodule

// File: rtl/sref_align_chk.sv
module sref_align_chk (
  input logic       clk,
  input logic       rst,
  input logic       ev,
  input logic       mask_div,
  input logic       mask_jesd,
  input logic       mask_dec,
  input logic       ddc_mode,
  input logic       nco_gate,
  input logic [1:0] div_phase,
  input logic       frame_strobe,
  input logic       lmfc_strobe,
  input logic       dec_strobe,
  input logic       nco_rst,
  input logic       misalign
);

  AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ev |=> !ev); // R2

  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ev && !mask_div) |=> (div_phase == 2'd0)); // R3

  AST_DIV_STEP: assert property (@(posedge clk) disable iff (rst)
    !ev |=> (div_phase == $past(div_phase) + 2'd1)); // R3

  AST_LMFC_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (ev && !mask_jesd) |=> (lmfc_strobe && frame_strobe)); // R4

  AST_LMFC_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    lmfc_strobe |-> frame_strobe); // R4

  AST_DEC_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (ev && ddc_mode && !mask_dec) |=> dec_strobe); // R5

  AST_NCO_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ev || nco_gate || !ddc_mode) |=> !nco_rst); // R6

  AST_MISALIGN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!ev || mask_jesd) |=> !misalign); // R8

  AST_MISALIGN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    misalign |-> lmfc_strobe); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (rst -> (div_phase == 2'd0 && !nco_rst && !misalign))); // R10

endmodule

bind sref_align_top sref_align_chk u_chk (
  .clk(clk), .rst(rst), .ev(sref_ev),
  .mask_div(mask_div), .mask_jesd(mask_jesd), .mask_dec(mask_dec),
  .ddc_mode(ddc_mode), .nco_gate(nco_gate),
  .div_phase(div_phase), .frame_strobe(frame_strobe),
  .lmfc_strobe(lmfc_strobe), .dec_strobe(dec_strobe),
  .nco_rst(nco_rst), .misalign(misalign)
);

// File: tb/sim_sref_align_top.sv
`timescale 1ns/1ps
module sim_sref_align_top;

  localparam int S  = 4;
  localparam int K  = 16;
  localparam int D  = 8;
  localparam int L  = S * K;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sysref_in = 1'b0;
  logic [2:0] dly_sel = 3'd0;
  logic       src_sel = 1'b0;
  logic       manual_bit = 1'b0;
  logic       mask_div = 1'b0;
  logic       mask_jesd = 1'b0;
  logic       mask_dec = 1'b0;
  logic       ddc_mode = 1'b1;
  logic       nco_gate = 1'b0;
  logic [1:0] div_phase;
  logic       frame_strobe, lmfc_strobe, dec_strobe, nco_rst, misalign;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sref_align_top #(
    .MAX_DLY(8), .SAMP_PER_FRAME(S), .FRAMES_PER_MF(K), .DEC_FACTOR(D)
  ) u0 (
    .clk(clk), .rst(rst), .sysref_in(sysref_in), .dly_sel(dly_sel),
    .src_sel(src_sel), .manual_bit(manual_bit), .mask_div(mask_div),
    .mask_jesd(mask_jesd), .mask_dec(mask_dec), .ddc_mode(ddc_mode),
    .nco_gate(nco_gate), .div_phase(div_phase), .frame_strobe(frame_strobe),
    .lmfc_strobe(lmfc_strobe), .dec_strobe(dec_strobe), .nco_rst(nco_rst),
    .misalign(misalign)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Manual pulse; returns at the negedge where all phases read zero.
  task automatic align_manual();
    src_sel    = 1'b1;
    manual_bit = 1'b1;
    step(3);
    manual_bit = 1'b0;
  endtask

  task automatic t_reset();
    step(3);
    chk("R10 div_phase in reset", div_phase, 0);
    chk("R10 lmfc_strobe in reset", lmfc_strobe, 0);
    chk("R10 nco_rst/misalign in reset", {nco_rst, misalign}, 0);
    rst = 1'b0;
    step(2);
  endtask

  task automatic t_free_run();
    int e_div = 0, e_frm = 0, e_lmfc = 0, e_dec = 0;
    align_manual();
    chk("R6 nco_rst at alignment", nco_rst, 1);
    chk("R5 dec_strobe at alignment", dec_strobe, 1);
    for (int k = 1; k <= 2 * L; k++) begin
      step(1);
      if (k == 1) chk("R6 nco_rst one cycle", nco_rst, 0);
      if (div_phase != 2'(k % 4)) e_div++;
      if (frame_strobe != ((k % S) == 0)) e_frm++;
      if (lmfc_strobe != ((k % L) == 0)) e_lmfc++;
      if (dec_strobe != ((k % D) == 0)) e_dec++;
    end
    chk("R3 divider sequence errors", e_div, 0);
    chk("R4 frame strobe errors", e_frm, 0);
    chk("R4 lmfc strobe errors", e_lmfc, 0);
    chk("R5 dec strobe errors", e_dec, 0);
  endtask

  task automatic t_ext_misaligned();
    align_manual();
    src_sel = 1'b0; dly_sel = 3'd0;
    step(10);
    sysref_in = 1'b1;
    step(2);
    chk("R1 no realign one cycle early", lmfc_strobe, 0);
    step(1);
    chk("R1 div_phase at landing d=0", div_phase, 0);
    chk("R1 lmfc_strobe at landing d=0", lmfc_strobe, 1);
    chk("R8 misalign on displaced edge", misalign, 1);
    sysref_in = 1'b0;
    step(1);
    chk("R8 misalign one cycle", misalign, 0);
    step(4);
  endtask

  task automatic t_delay_periodic();
    align_manual();
    src_sel = 1'b0; dly_sel = 3'd2;
    step(L - 5);
    sysref_in = 1'b1;
    step(4);
    chk("R1 d=2 not early", lmfc_strobe, 0);
    step(1);
    chk("R1 lmfc_strobe at landing d=2", lmfc_strobe, 1);
    chk("R9 first periodic edge no misalign", misalign, 0);
    sysref_in = 1'b0;
    step(L - 5);
    sysref_in = 1'b1;
    step(5);
    chk("R9 second periodic edge no misalign", misalign, 0);
    chk("R9 phase unchanged", {lmfc_strobe, div_phase}, 3'b100);
    sysref_in = 1'b0;
    dly_sel = 3'd0;
    step(8);
  endtask

  task automatic t_long_high();
    align_manual();
    src_sel = 1'b0; dly_sel = 3'd0;
    step(10);
    sysref_in = 1'b1;
    step(3);
    step(5);
    chk("R2 one realign while held high", div_phase, 1);
    step(20);
    chk("R2 still free-running", div_phase, 1);
    chk("R2 no further misalign", misalign, 0);
    sysref_in = 1'b0;
    step(4);
  endtask

  task automatic t_mask_div();
    align_manual();
    src_sel = 1'b0; mask_div = 1'b1;
    step(L - 1);
    sysref_in = 1'b1;
    step(3);
    chk("R3 masked divider keeps phase", div_phase, 2);
    chk("R4 lmfc realigned with divider masked", lmfc_strobe, 1);
    chk("R8 misalign with divider masked", misalign, 1);
    sysref_in = 1'b0; mask_div = 1'b0;
    step(4);
  endtask

  task automatic t_mask_jesd();
    align_manual();
    src_sel = 1'b0; mask_jesd = 1'b1;
    step(L - 1);
    sysref_in = 1'b1;
    step(3);
    chk("R4 masked lmfc not realigned", lmfc_strobe, 0);
    chk("R4 masked frame not realigned", frame_strobe, 0);
    chk("R3 divider realigned with lmfc masked", div_phase, 0);
    chk("R8 no misalign when lmfc masked", misalign, 0);
    sysref_in = 1'b0; mask_jesd = 1'b0;
    step(4);
  endtask

  task automatic t_ddc();
    align_manual();
    src_sel = 1'b0;
    step(L - 1);
    sysref_in = 1'b1;
    step(3);
    chk("R5 dec realigned in ddc mode", dec_strobe, 1);
    chk("R6 nco_rst in ddc mode", nco_rst, 1);
    sysref_in = 1'b0;
    step(4);
    align_manual();
    src_sel = 1'b0; mask_dec = 1'b1; nco_gate = 1'b1;
    step(L - 1);
    sysref_in = 1'b1;
    step(3);
    chk("R5 masked dec keeps phase", dec_strobe, 0);
    chk("R6 gated nco_rst", nco_rst, 0);
    sysref_in = 1'b0; mask_dec = 1'b0; nco_gate = 1'b0;
    step(4);
    align_manual();
    src_sel = 1'b0; ddc_mode = 1'b0;
    step(L - 1);
    sysref_in = 1'b1;
    step(3);
    chk("R5 dec not realigned outside ddc", dec_strobe, 0);
    chk("R6 no nco_rst outside ddc", nco_rst, 0);
    sysref_in = 1'b0; ddc_mode = 1'b1;
    step(4);
  endtask

  task automatic t_manual();
    align_manual();
    dly_sel = 3'd5;
    step(10);
    sysref_in = 1'b1;
    step(3);
    chk("R7 sysref_in ignored (div)", div_phase, 1);
    chk("R7 sysref_in ignored (lmfc)", lmfc_strobe, 0);
    sysref_in = 1'b0;
    step(5);
    manual_bit = 1'b1;
    step(3);
    chk("R7 manual edge realigns div", div_phase, 0);
    chk("R7 manual edge realigns lmfc", lmfc_strobe, 1);
    chk("R8 manual misalign", misalign, 1);
    step(10);
    chk("R7 held manual bit one event", div_phase, 2);
    manual_bit = 1'b0;
    dly_sel = 3'd0;
    step(4);
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_ext_misaligned();
    t_delay_periodic();
    t_long_high();
    t_mask_div();
    t_mask_jesd();
    t_ddc();
    t_manual();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule